// File: doc/BRIEF.md
# Busy-Flag Bundle Sequencer

This block is a single-threaded, in-order controller. It walks a small instruction memory of wide bundles, one bundle per clock. It does no reordering at run time. Each bundle holds:

- two scalar slots, which run locally against a register file of 32 words of 32 bits;
- four vector slots and two matrix slots, which are passed straight out to external execution units;
- one miscellaneous slot, which carries kernel launches, DMA starts, waits, jumps and a halt;
- six immediate fields.

Ordering between the external units comes only from software. A bank of four busy flags tracks the units: flag 0 is matrix unit 0, flag 1 is matrix unit 1, flag 2 is the vector unit and flag 3 is the DMA engine. Sending work to a unit raises its flag, and the unit's done pulse lowers it. A wait operation names one flag and holds the sequencer until that flag is low. Nothing else checks dependencies.

A host writes bundles through a write port and pulses `start`. It then watches `halted`. The register file can be read at any time through a combinational read port.

Top module: `flag_sync_sequencer`

## Requirements
- R1: After reset, `pc` is 0, all busy flags are 0, every register reads 0, and `halted` and all forward valids are 0.
- R2: A `start` pulse sets `pc` to 0 at the next edge and begins running. After that, one bundle runs per clock in address order.
- R3: Bundle layout is as follows. Immediate k sits at bits [16k+15:16k], for k = 0..5. Scalar slot s sits at bits [96+16s+15:96+16s], with op [2:0], rd [7:3], rs [12:8] and immediate select [15:13]. A select of 6 or 7 reads as zero. Scalar op codes are 1 = rd←imm, 2 = rd←rs+imm, 3 = rd←rs^imm and 4 = rd←rs−imm; other codes do nothing. Both slots run in the same cycle, and both read register values from before the bundle.
- R4: When both scalar slots write the same register, slot 1's value is stored.
- R5: Vector slot v is at bits [128+8v+7:128+8v] and matrix slot m is at bits [160+8m+7:160+8m], each with valid in bit 7 and op in bits [6:0]. A valid slot drives its `*_valid` bit and its 7-bit op field on the next clock. In that same cycle the unit's flag reads 1. All vector slots share flag 2.
- R6: A `unit_done` pulse clears its flag at the next edge. If a done pulse and a new issue to the same unit fall in the same cycle, the flag stays set.
- R7: The misc slot is op [178:176] with argument [186:179]. A wait (op 3) on flag arg[1:0] stalls while that flag reads 1. During a stall no slot of the bundle runs or is forwarded and `pc` holds. The bundle runs on the first cycle the flag reads 0.
- R8: A jump (op 4) sends the next fetch to arg[3:0]. The other slots of the jump bundle still run.
- R9: A launch (op 1) pulses `kern_valid` with `kern_id` = arg. A DMA start (op 2) pulses `dma_valid` with `dma_arg` = the register named by arg[4:0], and sets flag 3.
- R10: A halt (op 5) stops fetch with `pc` holding and raises `halted`. After that nothing more is issued until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_we | input | 1 | Bundle memory write enable |
| prog_addr | input | PCW | Bundle memory write address |
| prog_data | input | BW | Bundle to write |
| start | input | 1 | Begin running at bundle 0 |
| unit_done | input | 4 | Completion pulses, one per busy flag |
| reg_addr | input | 5 | Register read address |
| reg_data | output | 32 | Register read data |
| pc | output | PCW | Current fetch address |
| sync_flags | output | 4 | Busy flags |
| mat_valid | output | 2 | Matrix slot forward valids |
| mat_op | output | 14 | Matrix slot ops, 7 bits each |
| vec_valid | output | 4 | Vector slot forward valids |
| vec_op | output | 28 | Vector slot ops, 7 bits each |
| kern_valid | output | 1 | Kernel launch pulse |
| kern_id | output | 8 | Kernel launch argument |
| dma_valid | output | 1 | DMA start pulse |
| dma_arg | output | 32 | DMA argument from register |
| halted | output | 1 | Halt reached |

## Verification
The bench lines up a done pulse with a second issue to the same matrix unit. A design that lets completion win there would drop the flag, and a later wait would slip past work still in flight. It holds a wait on a busy flag for several cycles while that bundle also carries a scalar write. A sequencer that ran the slots, or moved `pc`, during the stall would show the register changed early. It writes one register from both scalar slots, and chains a read after a write inside one bundle. This catches the wrong winning slot and catches reads of the new value. Random scalar programs are compared against a bench model of the register file, and a jump bundle shows whether its own slots are skipped.

// File: rtl/flag_sync_sequencer.sv
module flag_sync_sequencer #(
  parameter int DEPTH = 16,
  parameter int IMMW  = 16,
  parameter int OPW   = 7,
  localparam int PCW  = $clog2(DEPTH),
  localparam int SLW  = OPW + 1,
  localparam int BW   = 6 * IMMW + 32 + 6 * SLW + 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prog_we,
  input  logic [PCW-1:0]     prog_addr,
  input  logic [BW-1:0]      prog_data,
  input  logic               start,
  input  logic [3:0]         unit_done,
  input  logic [4:0]         reg_addr,
  output logic [31:0]        reg_data,
  output logic [PCW-1:0]     pc,
  output logic [3:0]         sync_flags,
  output logic [1:0]         mat_valid,
  output logic [2*OPW-1:0]   mat_op,
  output logic [3:0]         vec_valid,
  output logic [4*OPW-1:0]   vec_op,
  output logic               kern_valid,
  output logic [7:0]         kern_id,
  output logic               dma_valid,
  output logic [31:0]        dma_arg,
  output logic               halted
);
  localparam int SC_LO   = 6 * IMMW;
  localparam int VEC_LO  = SC_LO + 32;
  localparam int MAT_LO  = VEC_LO + 4 * SLW;
  localparam int MISC_LO = MAT_LO + 2 * SLW;

  localparam logic [2:0] M_LAUNCH = 3'd1, M_DMA = 3'd2, M_WAIT = 3'd3,
                         M_JUMP = 3'd4, M_HALT = 3'd5;

  logic [BW-1:0] imem [DEPTH];
  logic [31:0]   regs [32];
  logic          running;

  always_ff @(posedge clk)
    if (prog_we) imem[prog_addr] <= prog_data;

  logic [BW-1:0] bnd;
  assign bnd = imem[pc];

  logic [2:0] mop;
  logic [7:0] marg;
  assign mop  = bnd[MISC_LO +: 3];
  assign marg = bnd[MISC_LO+3 +: 8];

  logic wait_blk, go;
  assign wait_blk = running && mop == M_WAIT && sync_flags[marg[1:0]];
  assign go       = running && !wait_blk;

  logic [31:0] immv [8];
  for (genvar k = 0; k < 8; k++) begin : g_imm
    if (k < 6) begin : g_real
      assign immv[k] = {{(32-IMMW){1'b0}}, bnd[k*IMMW +: IMMW]};
    end else begin : g_zero
      assign immv[k] = '0;
    end
  end

  logic        wen  [2];
  logic [4:0]  wdst [2];
  logic [31:0] wval [2];
  for (genvar s = 0; s < 2; s++) begin : g_sc
    logic [15:0] f;
    logic [31:0] src, iv;
    assign f    = bnd[SC_LO + 16*s +: 16];
    assign src  = regs[f[12:8]];
    assign iv   = immv[f[15:13]];
    assign wdst[s] = f[7:3];
    assign wen[s]  = go && f[2:0] >= 3'd1 && f[2:0] <= 3'd4;
    always_comb
      case (f[2:0])
        3'd1:    wval[s] = iv;
        3'd2:    wval[s] = src + iv;
        3'd3:    wval[s] = src ^ iv;
        3'd4:    wval[s] = src - iv;
        default: wval[s] = '0;
      endcase
  end

  logic [1:0] mat_iss;
  logic [3:0] vec_iss;
  for (genvar m = 0; m < 2; m++) begin : g_mat
    assign mat_iss[m] = go && bnd[MAT_LO + m*SLW + OPW];
  end
  for (genvar v = 0; v < 4; v++) begin : g_vec
    assign vec_iss[v] = go && bnd[VEC_LO + v*SLW + OPW];
  end

  logic dma_iss, kern_iss;
  assign dma_iss  = go && mop == M_DMA;
  assign kern_iss = go && mop == M_LAUNCH;

  logic [3:0] issue;
  assign issue = {dma_iss, |vec_iss, mat_iss};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) regs[i] <= '0;
    end else begin
      for (int s = 0; s < 2; s++)
        if (wen[s]) regs[wdst[s]] <= wval[s];
    end
  end
  assign reg_data = regs[reg_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= '0;
      running <= 1'b0;
      halted <= 1'b0;
      sync_flags <= '0;
      mat_valid <= '0;
      mat_op <= '0;
      vec_valid <= '0;
      vec_op <= '0;
      kern_valid <= 1'b0;
      kern_id <= '0;
      dma_valid <= 1'b0;
      dma_arg <= '0;
    end else begin
      sync_flags <= (sync_flags & ~unit_done) | issue;
      mat_valid  <= mat_iss;
      vec_valid  <= vec_iss;
      kern_valid <= kern_iss;
      dma_valid  <= dma_iss;
      for (int m = 0; m < 2; m++)
        if (mat_iss[m]) mat_op[m*OPW +: OPW] <= bnd[MAT_LO + m*SLW +: OPW];
      for (int v = 0; v < 4; v++)
        if (vec_iss[v]) vec_op[v*OPW +: OPW] <= bnd[VEC_LO + v*SLW +: OPW];
      if (kern_iss) kern_id <= marg;
      if (dma_iss) dma_arg <= regs[marg[4:0]];
      if (start) begin
        pc <= '0;
        running <= 1'b1;
        halted <= 1'b0;
      end else if (go) begin
        case (mop)
          M_HALT: begin
            running <= 1'b0;
            halted <= 1'b1;
          end
          M_JUMP:  pc <= marg[PCW-1:0];
          default: pc <= pc + 1'b1;
        endcase
      end
    end
  end
endmodule

module flag_sync_sequencer_chk #(
  parameter int PCW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           wait_blk,
  input logic [PCW-1:0] pc,
  input logic [3:0]     sync_flags,
  input logic [3:0]     unit_done,
  input logic [1:0]     mat_valid,
  input logic [3:0]     vec_valid,
  input logic           kern_valid,
  input logic           dma_valid,
  input logic           halted
);
  logic [3:0] issued_now;
  assign issued_now = {dma_valid, |vec_valid, mat_valid};

  p_flag_on_issue_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (issued_now & ~sync_flags) == 4'd0);

  p_done_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(unit_done) & ~issued_now & sync_flags) == 4'd0);

  p_stall_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_blk && !start) |=> ($stable(pc) && mat_valid == 2'd0 && vec_valid == 4'd0
                              && !kern_valid && !dma_valid));

  p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && $past(halted)) |-> (mat_valid == 2'd0 && vec_valid == 4'd0
                                   && !kern_valid && !dma_valid));

  p_halt_pc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !start) |=> $stable(pc));
endmodule

bind flag_sync_sequencer flag_sync_sequencer_chk #(.PCW(PCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .wait_blk(wait_blk), .pc(pc),
  .sync_flags(sync_flags), .unit_done(unit_done), .mat_valid(mat_valid),
  .vec_valid(vec_valid), .kern_valid(kern_valid), .dma_valid(dma_valid),
  .halted(halted)
);

// File: tb/flag_sync_sequencer_test.sv
module flag_sync_sequencer_test;
  localparam int BW = 187;

  logic clk = 1'b0, rst_n = 1'b0, prog_we = 1'b0, start = 1'b0;
  logic [3:0] prog_addr = '0;
  logic [BW-1:0] prog_data = '0;
  logic [3:0] unit_done = '0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_data, dma_arg;
  logic [3:0] pc, sync_flags, vec_valid;
  logic [1:0] mat_valid;
  logic [13:0] mat_op;
  logic [27:0] vec_op;
  logic kern_valid, dma_valid, halted;
  logic [7:0] kern_id;

  int total = 0, fails = 0;
  logic [31:0] model [32];

  flag_sync_sequencer uut (.*);

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] sc(input int op, input int rd, input int rs, input int isel);
    return {isel[2:0], rs[4:0], rd[4:0], op[2:0]};
  endfunction

  function automatic logic [BW-1:0] misc(input logic [BW-1:0] b, input int op, input int arg);
    b[178:176] = op[2:0];
    b[186:179] = arg[7:0];
    return b;
  endfunction

  task automatic load(input int a, input logic [BW-1:0] b);
    @(negedge clk);
    prog_we = 1'b1; prog_addr = a[3:0]; prog_data = b;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic kick();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_halt();
    for (int i = 0; i < 200 && !halted; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] rd_model_imm(input logic [BW-1:0] b, input int isel);
    return (isel < 6) ? {16'd0, b[isel*16 +: 16]} : 32'd0;
  endfunction

  task automatic rchk(input int r, input logic [31:0] exp, input string req);
    reg_addr = r[4:0];
    #0.1;
    chk(reg_data === exp, req, reg_data, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [BW-1:0] b;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(pc == 0 && sync_flags == 0 && !halted && mat_valid == 0 && vec_valid == 0
        && !kern_valid && !dma_valid, "R1", {pc, sync_flags, 7'd0, halted}, 0);
    for (int r = 0; r < 32; r += 7) rchk(r, 0, "R1");

    // Forwarding, launch, DMA, jump
    b = '0; b[15:0] = 16'h1234; b[31:16] = 16'h0077; b[47:32] = 16'h0099;
    b[96 +: 16] = sc(1, 6, 0, 0);
    b[128 +: 8] = 8'h91; b[144 +: 8] = 8'hA2; b[152 +: 8] = 8'hB3;
    b[168 +: 8] = 8'hC4;
    load(0, misc(b, 1, 8'hA5));
    b[96 +: 16] = 0; b[128 +: 48] = '0;
    load(1, misc(b, 2, 6));
    b[96 +: 16] = sc(1, 7, 0, 1);
    load(2, misc(b, 4, 5));
    b[96 +: 16] = sc(1, 8, 0, 0);
    load(3, misc(b, 0, 0));
    load(4, misc(b, 5, 0));
    b[96 +: 16] = sc(1, 9, 0, 2);
    load(5, misc(b, 0, 0));
    b[96 +: 16] = 0;
    load(6, misc(b, 5, 0));
    kick();
    @(negedge clk);
    chk(vec_valid == 4'b1101, "R5 vec valid", vec_valid, 4'b1101);
    chk(vec_op[6:0] == 7'h11 && vec_op[20:14] == 7'h22 && vec_op[27:21] == 7'h33,
        "R5 vec op", vec_op, 28'h0);
    chk(mat_valid == 2'b10 && mat_op[13:7] == 7'h44, "R5 mat", {mat_valid, mat_op}, {2'b10, 7'h44, 7'h0});
    chk(sync_flags == 4'b0110, "R5 flags", sync_flags, 4'b0110);
    chk(kern_valid && kern_id == 8'hA5, "R9 launch", {kern_valid, kern_id}, 9'h1A5);
    @(negedge clk);
    chk(dma_valid && dma_arg == 32'h1234 && sync_flags[3], "R9 dma", dma_arg, 32'h1234);
    chk(!kern_valid && vec_valid == 0, "R9 launch pulse", {kern_valid, vec_valid}, 0);
    @(negedge clk);
    chk(pc == 5, "R8 jump pc", pc, 5);
    wait_halt();
    chk(halted == 1'b1, "R10 halted", halted, 1);
    rchk(7, 32'h77, "R8 jump slot");
    rchk(8, 0, "R8 skipped");
    rchk(9, 32'h99, "R8 target");
    unit_done = 4'hF; @(negedge clk); unit_done = 0; @(negedge clk);
    chk(sync_flags == 0, "R6 clear all", sync_flags, 0);

    // Issue/done collision and wait stall
    b = '0; b[15:0] = 16'd1;
    b[160 +: 8] = 8'h85;
    load(0, b);
    b[160 +: 8] = 8'h86;
    load(1, b);
    b[160 +: 8] = 0; b[96 +: 16] = sc(1, 5, 0, 0);
    load(2, misc(b, 3, 0));
    b[96 +: 16] = 0;
    load(3, misc(b, 5, 0));
    kick();
    @(negedge clk);
    chk(mat_valid == 2'b01 && mat_op[6:0] == 7'h05 && sync_flags[0], "R5 mat0", mat_op[6:0], 5);
    unit_done = 4'b0001;
    @(negedge clk);
    chk(sync_flags[0] == 1'b1, "R6 issue wins", sync_flags[0], 1);
    chk(mat_op[6:0] == 7'h06, "R2 order", mat_op[6:0], 6);
    unit_done = 0;
    @(negedge clk);
    chk(pc == 2, "R7 stall pc", pc, 2);
    rchk(5, 0, "R7 no slot during stall");
    @(negedge clk); @(negedge clk);
    chk(pc == 2 && mat_valid == 0, "R7 still stalled", pc, 2);
    rchk(5, 0, "R7 no slot during stall");
    unit_done = 4'b0001;
    @(negedge clk);
    unit_done = 0;
    chk(sync_flags[0] == 1'b0, "R6 done clears", sync_flags[0], 0);
    chk(pc == 2, "R7 flag read before clear", pc, 2);
    @(negedge clk);
    chk(pc == 3, "R7 proceeds", pc, 3);
    rchk(5, 1, "R7 wait bundle runs");
    @(negedge clk);
    chk(halted == 1'b1, "R10 halt", halted, 1);
    @(negedge clk); @(negedge clk);
    chk(pc == 3 && mat_valid == 0, "R10 pc holds", pc, 3);

    // Dual write and read-before-write
    b = '0; b[15:0] = 16'd1; b[31:16] = 16'd2; b[47:32] = 16'd5; b[63:48] = 16'd3; b[79:64] = 16'hF;
    b[96 +: 16] = sc(1, 10, 0, 0); b[112 +: 16] = sc(1, 10, 0, 1);
    load(0, b);
    b[96 +: 16] = sc(1, 12, 0, 2); b[112 +: 16] = 0;
    load(1, b);
    b[96 +: 16] = sc(2, 12, 12, 3); b[112 +: 16] = sc(3, 13, 12, 4);
    load(2, b);
    b[96 +: 32] = 0;
    load(3, misc(b, 5, 0));
    kick();
    wait_halt();
    rchk(10, 2, "R4 slot1 wins");
    rchk(12, 8, "R3 addi");
    rchk(13, 32'hA, "R3 old value read");
    for (int r = 0; r < 32; r++) begin
      reg_addr = r[4:0]; #0.1; model[r] = reg_data;
    end

    // Random scalar programs (R2, R3, R4)
    for (int p = 0; p < 20; p++) begin
      logic [31:0] nx [32];
      for (int a = 0; a < 15; a++) begin
        b = '0;
        for (int k = 0; k < 6; k++) b[k*16 +: 16] = 16'($urandom);
        for (int s = 0; s < 2; s++) b[96 + 16*s +: 16] = 16'($urandom);
        load(a, b);
        nx = model;
        for (int s = 0; s < 2; s++) begin
          logic [15:0] f;
          logic [31:0] iv, src;
          f = b[96 + 16*s +: 16];
          iv = rd_model_imm(b, int'(f[15:13]));
          src = model[f[12:8]];
          case (f[2:0])
            3'd1: nx[f[7:3]] = iv;
            3'd2: nx[f[7:3]] = src + iv;
            3'd3: nx[f[7:3]] = src ^ iv;
            3'd4: nx[f[7:3]] = src - iv;
            default: ;
          endcase
        end
        model = nx;
      end
      load(15, misc('0, 5, 0));
      kick();
      wait_halt();
      chk(halted, "R2 random program halts", halted, 1);
      for (int r = 0; r < 32; r++) rchk(r, model[r], "R3 random");
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule